// File: doc/BRIEF.md
# Indexed Precision Gamma Palette

This block is a per-channel gamma lookup table for a display pixel pipe. The table holds 1024 entries. Each entry carries a 10-bit red, green and blue output value. Software loads and inspects the table through a small register port: it writes a pointer into the index register, then moves words through the data register. An auto-increment flag in the index register lets a whole table stream through the data register with a single index write. Without the flag, the pointer stays where software put it.

A split flag in the same register cuts the table into two 512-entry halves. The lower half, starting at entry 0, acts as a degamma curve. The upper half, starting at entry 512, acts as the gamma curve. Pixels enter as three 11-bit components in unsigned 1.10 form. In normal mode, the ten fraction bits address the full table. In split mode, a component first indexes the lower half with its upper nine bits. The result then indexes the upper half in the same way. When a component has its integer bit set (at or beyond 1.0), the table is skipped and the output comes from that channel's clamp register. After a table load, software is expected to write the index register back to zero.

Top module: `gamma_palette`

## Requirements
- R1: A data-register write (address 1) stores reg_wdata[29:0] into the entry at the current index, with red in bits 29:20, green in 19:10 and blue in 9:0. A data-register read returns that entry zero-extended on reg_rdata one cycle after reg_rd. A read issued together with a write is ignored.
- R2: The index register (address 0) holds the entry pointer in bits 9:0, the split flag in bit 30 and the auto-increment flag in bit 31. It reads back with all other bits zero.
- R3: With auto-increment clear, data writes and reads leave the index unchanged, so repeated writes land on the same entry.
- R4: With auto-increment set and split clear, every data write and every data read advances the index by one, wrapping from 1023 to 0.
- R5: With auto-increment and split both set, the index advances within its current half: 511 wraps to 0 and 1023 wraps to 512.
- R6: In normal mode, a pixel accepted at a clock edge appears on out_valid two edges later. Each output channel is {1'b0, entry[component[9:0]].channel}.
- R7: In split mode, each output channel is {1'b0, entry[512 + d[9:1]].channel}, where d = entry[component[9:1]].channel from the lower half.
- R8: A component with bit 10 set outputs bits 16:6 of that channel's clamp register, in either mode.
- R9: The clamp registers for red, green and blue sit at addresses 2, 3 and 4. Each is 17 bits wide, where 1<<16 stands for 1.0, and reads back zero-extended.
- R10: A register write in the same cycle as pix_valid drops that pixel, so no out_valid follows for it.
- R11: After reset, the index register reads 0, out_valid is low and each clamp register reads 0x10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select: 0 index, 1 data, 2..4 clamp red/green/blue |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| pix_valid | input | 1 | Pixel input qualifier |
| pix_r | input | 11 | Red component, unsigned 1.10 |
| pix_g | input | 11 | Green component, unsigned 1.10 |
| pix_b | input | 11 | Blue component, unsigned 1.10 |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | 11 | Red result, unsigned 1.10 |
| out_g | output | 11 | Green result, unsigned 1.10 |
| out_b | output | 11 | Blue result, unsigned 1.10 |

## Verification
The bench builds the block with its default parameters: 10-bit channels and a 17-bit clamp format. At that size every one of the 1024 input codes can be streamed back to back through both lookup modes, with each channel on a different offset of the sweep. Every entry of both halves is loaded through auto-increment streaming. This brings each wrap point of the index (1023 to 0, 511 to 0, 1023 to 512) and every table address within reach. Clamp values, write priority over pixels and the register readback encodings are checked with directed cases.

// File: rtl/gpal_pkg.sv
// Shared constants for the gamma palette: register selects, index-register
// flag positions and channel count. Assumes a 32-bit register data bus.
package gpal_pkg;
    localparam int          NCH        = 3;     // red, green, blue
    localparam logic [2:0]  REG_INDEX  = 3'd0;
    localparam logic [2:0]  REG_DATA   = 3'd1;
    localparam logic [2:0]  REG_MAX0   = 3'd2;  // red; green and blue follow
    localparam int          AUTO_BIT   = 31;
    localparam int          SPLIT_BIT  = 30;
    localparam int          BUS_W      = 32;
endpackage

// File: rtl/gpal_regs.sv
// Register file of the gamma palette: index pointer with its split and
// auto-increment flags, three clamp registers and the registered read mux.
// Assumes 3*CH_W <= 30 so that the packed entry fits below the flag bits.
module gpal_regs
    import gpal_pkg::*;
#(
    parameter int CH_W  = 10,
    parameter int MAX_W = 17
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [2:0]                    reg_addr,
    input  logic [BUS_W-1:0]              reg_wdata,
    input  logic [NCH*CH_W-1:0]           tab_rword,
    output logic [BUS_W-1:0]              reg_rdata,
    output logic [CH_W-1:0]               idx,
    output logic                          split,
    output logic                          autoinc,
    output logic                          tab_we,
    output logic [NCH*CH_W-1:0]           tab_wdata,
    output logic [NCH-1:0][MAX_W-1:0]     max_q
);
    localparam logic [MAX_W-1:0] MAX_RST = MAX_W'(1) << (MAX_W - 1);

    logic            wr_index, wr_data, rd_data, step;
    logic [CH_W-1:0] idx_next_step;
    logic [BUS_W-1:0] rd_next;

    assign wr_index  = reg_wr && (reg_addr == REG_INDEX);
    assign wr_data   = reg_wr && (reg_addr == REG_DATA);
    assign rd_data   = reg_rd && !reg_wr && (reg_addr == REG_DATA);
    assign step      = autoinc && (wr_data || rd_data);
    assign tab_we    = wr_data;
    assign tab_wdata = reg_wdata[NCH*CH_W-1:0];

    // Next pointer: wrap inside the current half in split mode, else full range.
    always_comb begin
        if (split)
            idx_next_step = {idx[CH_W-1], idx[CH_W-2:0] + 1'b1};
        else
            idx_next_step = idx + 1'b1;
    end

    // Index register and its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            split   <= 1'b0;
            autoinc <= 1'b0;
        end else if (wr_index) begin
            idx     <= reg_wdata[CH_W-1:0];
            split   <= reg_wdata[SPLIT_BIT];
            autoinc <= reg_wdata[AUTO_BIT];
        end else if (step) begin
            idx     <= idx_next_step;
        end
    end

    // One clamp register per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_max
        localparam logic [2:0] SEL = REG_MAX0 + 3'(c);
        always_ff @(posedge clk) begin
            if (!rst_n)
                max_q[c] <= MAX_RST;
            else if (reg_wr && reg_addr == SEL)
                max_q[c] <= reg_wdata[MAX_W-1:0];
        end
    end

    // Read mux: select the register image for the addressed register.
    always_comb begin
        rd_next = '0;
        case (reg_addr)
            REG_INDEX: begin
                rd_next[CH_W-1:0] = idx;
                rd_next[SPLIT_BIT] = split;
                rd_next[AUTO_BIT]  = autoinc;
            end
            REG_DATA:  rd_next[NCH*CH_W-1:0] = tab_rword;
            REG_MAX0:  rd_next[MAX_W-1:0] = max_q[0];
            REG_MAX0 + 3'd1: rd_next[MAX_W-1:0] = max_q[1];
            REG_MAX0 + 3'd2: rd_next[MAX_W-1:0] = max_q[2];
            default:   rd_next = '0;
        endcase
    end

    // Registered read data, updated only by an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd && !reg_wr)
            reg_rdata <= rd_next;
    end
endmodule

// File: rtl/gpal_table.sv
// Table storage: 2**CH_W packed entries with one write port, one full-word
// read port for the register side and 2*NCH per-channel read lanes for the
// pixel pipe. Lane l returns channel (l mod NCH). Contents are not reset.
module gpal_table
    import gpal_pkg::*;
#(
    parameter int CH_W = 10
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [CH_W-1:0]               waddr,
    input  logic [NCH*CH_W-1:0]           wdata,
    input  logic [CH_W-1:0]               reg_raddr,
    output logic [NCH*CH_W-1:0]           reg_rword,
    input  logic [2*NCH-1:0][CH_W-1:0]    lane_addr,
    output logic [2*NCH-1:0][CH_W-1:0]    lane_data
);
    localparam int DEPTH = 1 << CH_W;
    localparam int W     = NCH * CH_W;

    logic [W-1:0] mem [DEPTH];

    // Single write port driven by the data register.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign reg_rword = mem[reg_raddr];

    // Per-channel lanes; red occupies the top field of a word.
    for (genvar l = 0; l < 2*NCH; l++) begin : g_lane
        localparam int CH = l % NCH;
        localparam int LO = (NCH - 1 - CH) * CH_W;
        logic [W-1:0] word;
        assign word         = mem[lane_addr[l]];
        assign lane_data[l] = word[LO +: CH_W];
    end
endmodule

// File: rtl/gpal_pipe.sv
// Two-stage pixel lookup. Stage A reads the full table (normal mode) or the
// lower half (split mode). Stage B reads the upper half in split mode, or
// passes stage A through, and applies the clamp for over-range inputs.
// A pixel presented together with a register write is discarded.
module gpal_pipe
    import gpal_pkg::*;
#(
    parameter int CH_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pix_valid,
    input  logic [NCH-1:0][CH_W:0]        pix,
    input  logic                          drop,
    input  logic                          split,
    input  logic [NCH-1:0][CH_W:0]        clamp,
    output logic [2*NCH-1:0][CH_W-1:0]    lane_addr,
    input  logic [2*NCH-1:0][CH_W-1:0]    lane_data,
    output logic                          out_valid,
    output logic [NCH-1:0][CH_W:0]        out_pix
);
    logic                     s1_valid, s1_split;
    logic [NCH-1:0]           s1_ovr;
    logic [NCH-1:0][CH_W-1:0] s1_val;

    // Stage A control: qualify the pixel and capture the mode it saw.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_split <= 1'b0;
        end else begin
            s1_valid <= pix_valid && !drop;
            s1_split <= split;
        end
    end

    // Stage B control: valid follows the pixel by one more cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= s1_valid;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Lower-half address in split mode, full address otherwise.
        assign lane_addr[c] = split ? {1'b0, pix[c][CH_W-1:1]} : pix[c][CH_W-1:0];
        // Upper-half address formed from the stage A result.
        assign lane_addr[NCH+c] = {1'b1, s1_val[c][CH_W-1:1]};

        // Stage A data: first lookup result and over-range flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_val[c] <= '0;
                s1_ovr[c] <= 1'b0;
            end else begin
                s1_val[c] <= lane_data[c];
                s1_ovr[c] <= pix[c][CH_W];
            end
        end

        // Stage B data: clamp, second lookup or pass-through.
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_pix[c] <= '0;
            else if (s1_ovr[c])
                out_pix[c] <= clamp[c];
            else if (s1_split)
                out_pix[c] <= {1'b0, lane_data[NCH+c]};
            else
                out_pix[c] <= {1'b0, s1_val[c]};
        end
    end
endmodule

// File: rtl/gamma_palette.sv
// Top of the indexed gamma palette: register port, table storage and the
// pixel lookup pipe. Pixels are unsigned 1.10 per channel; outputs likewise.
// Assumes MAX_W > CH_W and 3*CH_W <= 30.
module gamma_palette
    import gpal_pkg::*;
#(
    parameter int CH_W  = 10,
    parameter int MAX_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             pix_valid,
    input  logic [CH_W:0]    pix_r,
    input  logic [CH_W:0]    pix_g,
    input  logic [CH_W:0]    pix_b,
    output logic             out_valid,
    output logic [CH_W:0]    out_r,
    output logic [CH_W:0]    out_g,
    output logic [CH_W:0]    out_b
);
    logic [CH_W-1:0]               cur_idx;
    logic                          cur_split, cur_auto;
    logic                          tab_we;
    logic [NCH*CH_W-1:0]           tab_wdata, tab_rword;
    logic [NCH-1:0][MAX_W-1:0]     max_q;
    logic [NCH-1:0][CH_W:0]        clamp, pix_bus, out_bus;
    logic [2*NCH-1:0][CH_W-1:0]    lane_addr, lane_data;

    assign pix_bus[0] = pix_r;
    assign pix_bus[1] = pix_g;
    assign pix_bus[2] = pix_b;
    assign out_r = out_bus[0];
    assign out_g = out_bus[1];
    assign out_b = out_bus[2];

    // Clamp output: top CH_W+1 bits of each clamp register (1.0 -> 1<<CH_W).
    for (genvar c = 0; c < NCH; c++) begin : g_clamp
        assign clamp[c] = max_q[c][MAX_W-1 -: CH_W+1];
    end

    gpal_regs #(.CH_W(CH_W), .MAX_W(MAX_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .tab_rword(tab_rword),
        .reg_rdata(reg_rdata), .idx(cur_idx), .split(cur_split),
        .autoinc(cur_auto), .tab_we(tab_we), .tab_wdata(tab_wdata),
        .max_q(max_q)
    );

    gpal_table #(.CH_W(CH_W)) table_i (
        .clk(clk), .we(tab_we), .waddr(cur_idx), .wdata(tab_wdata),
        .reg_raddr(cur_idx), .reg_rword(tab_rword),
        .lane_addr(lane_addr), .lane_data(lane_data)
    );

    gpal_pipe #(.CH_W(CH_W)) pipe_i (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix(pix_bus),
        .drop(reg_wr), .split(cur_split), .clamp(clamp),
        .lane_addr(lane_addr), .lane_data(lane_data),
        .out_valid(out_valid), .out_pix(out_bus)
    );
endmodule

// File: rtl/gpal_checker.sv
// Protocol checker for gamma_palette, bound to every instance of the top.
// Watches the register port, the pixel qualifiers and the index pointer.
module gpal_checker #(
    parameter int CH_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    input  logic            pix_valid,
    input  logic            out_valid,
    input  logic [CH_W-1:0] cur_idx,
    input  logic            cur_split,
    input  logic            cur_auto
);
    // R6: an accepted pixel yields out_valid two cycles later
    p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !reg_wr) |=> ##1 out_valid);

    // R10: a pixel presented with a register write produces no output
    p_write_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && reg_wr) |=> ##1 !out_valid);

    // R2: an index write loads the pointer field
    p_index_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0) |=> cur_idx == $past(reg_wdata[CH_W-1:0]));

    // R3: without auto-increment a data write keeps the pointer
    p_index_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1 && !cur_auto) |=> $stable(cur_idx));

    // R4: auto-increment in normal mode steps the pointer by one
    p_index_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1 && cur_auto && !cur_split)
        |=> cur_idx == CH_W'($past(cur_idx) + 1'b1));

    // R5: auto-increment in split mode stays inside the current half
    p_half_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1 && cur_auto && cur_split)
        |=> cur_idx[CH_W-1] == $past(cur_idx[CH_W-1]));
endmodule

bind gamma_palette gpal_checker #(.CH_W(CH_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pix_valid(pix_valid), .out_valid(out_valid),
    .cur_idx(cur_idx), .cur_split(cur_split), .cur_auto(cur_auto)
);

// File: tb/gamma_palette_tb_top.sv
// Self-checking bench: loads the table through the register port, sweeps
// every input code in both modes and checks clamps, priority and readback.
module gamma_palette_tb_top;
    localparam int CW = 10;
    localparam logic [31:0] AUTO  = 32'h8000_0000;
    localparam logic [31:0] SPLIT = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_valid = 1'b0;
    logic [CW:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic        out_valid;
    logic [CW:0] out_r, out_g, out_b;

    int n_checks = 0;
    int n_errors = 0;
    logic [29:0] model [1024];

    always #5 clk = ~clk;

    gamma_palette dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [CW-1:0] fld(input logic [29:0] w, input int ch);
        return w[(2-ch)*CW +: CW];
    endfunction

    // One pixel, sampled when its result is due.
    task automatic one_pixel(input logic [CW:0] r, input logic [CW:0] g, input logic [CW:0] b,
                             input logic with_wr, output logic [33:0] res);
        @(negedge clk);
        pix_valid = 1'b1; pix_r = r; pix_g = g; pix_b = b;
        if (with_wr) begin reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h0001_0000; end
        @(negedge clk);
        pix_valid = 1'b0; reg_wr = 1'b0;
        @(negedge clk);
        res = {out_valid, out_r, out_g, out_b};
    endtask

    // Stream all codes back to back; expected value from the bench model.
    task automatic sweep(input logic split_mode, input string req);
        logic [CW:0] hist [3][1026];
        for (int k = 0; k < 1026; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                logic [32:0] exp;
                for (int c = 0; c < 3; c++) begin
                    logic [CW-1:0] code, d, v;
                    code = hist[c][k-2][CW-1:0];
                    if (split_mode) begin
                        d = fld(model[{1'b0, code[CW-1:1]}], c);
                        v = fld(model[{1'b1, d[CW-1:1]}], c);
                    end else begin
                        v = fld(model[code], c);
                    end
                    exp[(2-c)*11 +: 11] = {1'b0, v};
                end
                check({req, " out"}, {31'b0, out_valid, out_r, out_g, out_b}, {31'b0, 1'b1, exp});
            end
            if (k < 1024) begin
                pix_valid = 1'b1;
                pix_r = 11'(k);
                pix_g = 11'((k + 1) % 1024);
                pix_b = 11'((k + 500) % 1024);
                hist[0][k] = pix_r; hist[1][k] = pix_g; hist[2][k] = pix_b;
            end else begin
                pix_valid = 1'b0;
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [33:0] res;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        check("R11 out_valid", {63'b0, out_valid}, 64'd0);
        rd(3'd0, d); check("R11 index", {32'b0, d}, 64'd0);
        for (int c = 0; c < 3; c++) begin
            rd(3'(2 + c), d); check("R11 clamp", {32'b0, d}, 64'h1_0000);
        end

        // R2: index field and flag positions
        wr(3'd0, 32'hC000_0123); rd(3'd0, d); check("R2 readback", {32'b0, d}, 64'hC000_0123);
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); check("R2 masked", {32'b0, d}, 64'hC000_03FF);
        wr(3'd0, 32'h0);

        // R1 and R3: fixed index, data overwritten in place
        wr(3'd0, 32'h2A);
        wr(3'd1, 32'h3FF0_0801);
        rd(3'd1, d); check("R1 data", {32'b0, d}, 64'h3FF0_0801);
        wr(3'd1, 32'h1234_5678);
        rd(3'd1, d); check("R3 same entry", {32'b0, d}, 64'h1234_5678 & 64'h3FFF_FFFF);
        rd(3'd0, d); check("R3 index held", {32'b0, d}, 64'h2A);

        // R4: full normal-mode load through auto-increment
        wr(3'd0, AUTO);
        for (int i = 0; i < 1024; i++) begin
            model[i] = {10'(i ^ 'h155), 10'(1023 - i), 10'((i * 7) % 1024)};
            wr(3'd1, {2'b0, model[i]});
        end
        rd(3'd0, d); check("R4 wrap after load", {32'b0, d}, {32'b0, AUTO});
        for (int i = 0; i < 3; i++) begin
            rd(3'd1, d); check("R4 read stream", {32'b0, d}, {34'b0, model[i]});
        end
        rd(3'd0, d); check("R4 read advance", {32'b0, d}, {32'b0, AUTO | 32'd3});
        wr(3'd0, AUTO | 32'd1023);
        rd(3'd1, d); check("R4 top entry", {32'b0, d}, {34'b0, model[1023]});
        rd(3'd0, d); check("R4 read wrap", {32'b0, d}, {32'b0, AUTO});
        wr(3'd0, 32'h0);

        // R6: normal-mode sweep of every code
        sweep(1'b0, "R6");

        // R8 and R9: clamp registers
        one_pixel(11'h405, 11'h010, 11'h020, 1'b0, res);
        check("R8 default clamp", {30'b0, res}, {30'b0, 1'b1, 11'd1024, 1'b0, fld(model[16], 1), 1'b0, fld(model[32], 2)});
        wr(3'd3, 32'h0000_C000);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, d); check("R9 width", {32'b0, d}, 64'h1_FFFF);
        one_pixel(11'h003, 11'h400, 11'h7FF, 1'b0, res);
        check("R8 programmed clamp", {30'b0, res}, {30'b0, 1'b1, 1'b0, fld(model[3], 0), 11'h300, 11'h7FF});

        // R10: write in the same cycle drops the pixel
        one_pixel(11'h001, 11'h001, 11'h001, 1'b1, res);
        check("R10 dropped", {63'b0, res[33]}, 64'd0);

        // R5: split halves loaded with wrap checks
        wr(3'd0, SPLIT | AUTO);
        for (int i = 0; i < 512; i++) begin
            model[i] = {10'((i * 3) % 1024), 10'(1023 - i), 10'((i * 5 + 17) % 1024)};
            wr(3'd1, {2'b0, model[i]});
        end
        rd(3'd0, d); check("R5 lower wrap", {32'b0, d}, {32'b0, SPLIT | AUTO});
        wr(3'd0, SPLIT | AUTO | 32'd512);
        for (int j = 0; j < 512; j++) begin
            model[512 + j] = {10'((j * 2 + 1) % 1024), 10'(j ^ 'h0AA), 10'(1023 - j)};
            wr(3'd1, {2'b0, model[512 + j]});
        end
        rd(3'd0, d); check("R5 upper wrap", {32'b0, d}, {32'b0, SPLIT | AUTO | 32'd512});

        // R7: split-mode sweep of every code
        wr(3'd0, SPLIT);
        sweep(1'b1, "R7");
        wr(3'd0, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule